// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block turns the active-pixel and line strobes of a display timing generator into byte read addresses for one primary display plane. Software programs a buffer base address, the frame width in pixels, the pixel depth in bits, and a window (position, destination size and source size) through a narrow register write port. For every active pixel the block issues one byte address, stepping by the pixel size inside a line and jumping by a 16-byte aligned line pitch at each line end. Each frame restarts at the base address.

A base address written mid-frame waits in a pending register and is taken up at the next frame start, so a frame never straddles two buffers. The block also flags a window that cannot be shown without scaling or that leaves the active area, and it issues no addresses while that flag stands. The auto-centering corners for a full-screen plane are driven from the display size.

Top module: `fb_scan_addr_gen`

## Requirements
- R1: Register 1 holds the frame width in pixels and register 2 the pixel depth in bits (8, 16, 24 or 32; bytes per pixel = depth/8); the line pitch equals width times bytes per pixel rounded up to the next multiple of 16 bytes.
- R2: `line_pitch_o` and `fetch_len_o` both carry the same padded pitch value.
- R3: `fmt_code_o` equals depth divided by 16 with the remainder dropped: 8 gives 0, 16 and 24 give 1, 32 gives 2.
- R4: A base address written to register 0 takes effect only at the next `frame_start_i`; addresses of the frame in progress continue from the old buffer.
- R5: A cycle with `pix_vld_i` high (and no frame or line strobe) yields `rd_vld_o` with `rd_addr_o` on the following cycle; successive pixels advance the address by the bytes per pixel.
- R6: Each `line_end_i` moves the next line start by the line pitch, so line n of a frame starts at base + n times pitch.
- R7: Cycles with no strobe leave the address unchanged; the next active pixel continues where the previous one stopped.
- R8: Register 3 holds x in bits 15:0 and y in bits 31:16, both two's complement; a negative x or y sets `win_err_o`.
- R9: Register 4 holds the destination width in bits 15:0 and height in bits 31:16; `win_err_o` is set when x + width exceeds `disp_w_i` or y + height exceeds `disp_h_i`; an exact fit is legal.
- R10: Register 5 holds the source width (bits 15:0) and height (bits 31:16); any difference from the destination size sets `win_err_o`.
- R11: `win_err_o` follows a configuration change one cycle after the register write, and no `rd_vld_o` is raised while it is high.
- R12: `ctr_right_o` equals `disp_w_i` - 1 and `ctr_bottom_o` equals `disp_h_i` - 1.
- R13: After reset `rd_vld_o` and `win_err_o` are low, the depth is 32 (`fmt_code_o` = 2), and the pitch is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register select (0 base, 1 width, 2 depth, 3 position, 4 destination size, 5 source size) |
| cfg_wdata_i | input | ADDR_W | Register write data |
| frame_start_i | input | 1 | Frame start strobe |
| line_end_i | input | 1 | End of active line strobe |
| pix_vld_i | input | 1 | Active pixel strobe |
| disp_w_i | input | DIM_W | Active display width in pixels |
| disp_h_i | input | DIM_W | Active display height in lines |
| rd_addr_o | output | ADDR_W | Byte read address |
| rd_vld_o | output | 1 | Read address valid |
| fmt_code_o | output | 2 | Pixel format code |
| line_pitch_o | output | DIM_W+4 | Padded line pitch in bytes |
| fetch_len_o | output | DIM_W+4 | Padded line fetch length in bytes |
| win_err_o | output | 1 | Window invalid flag |
| ctr_right_o | output | DIM_W | Auto-centering right edge |
| ctr_bottom_o | output | DIM_W | Auto-centering bottom edge |

## Verification
The assertions watch every cycle for the counter's step rules: a held address in idle cycles, a pixel-sized step per active pixel, a pitch-sized jump at line end, a reload of the pending base at frame start, silence after an error cycle, and the 16-byte padding bound of the pitch. Only the bench scenarios show that a mid-frame base write leaves the running frame alone, that whole lines land at base plus multiples of the pitch, and that each window rule trips exactly at its boundary and clears again.

// File: rtl/fbsag_pkg.sv
package fbsag_pkg;
  typedef enum logic [2:0] {
    REG_BASE  = 3'd0,
    REG_WIDTH = 3'd1,
    REG_DEPTH = 3'd2,
    REG_POS   = 3'd3,
    REG_DST   = 3'd4,
    REG_SRC   = 3'd5
  } cfg_reg_e;

  localparam logic [5:0] DEPTH_RST = 6'd32;
  localparam int unsigned PAD_BYTES = 16;
endpackage

// File: rtl/fbsag_stride.sv
module fbsag_stride #(
  parameter int unsigned DIM_W = 16,
  parameter int unsigned SW    = DIM_W + 4
) (
  input  logic [DIM_W-1:0] width_i,
  input  logic [5:0]       depth_i,
  output logic [SW-1:0]    stride_o,
  output logic [1:0]       fmt_o,
  output logic [2:0]       step_o
);
  localparam int unsigned PB = fbsag_pkg::PAD_BYTES;
  localparam int unsigned LB = $clog2(PB);

  logic [SW-1:0] raw;
  logic [SW-1:0] raw_up;

  always_comb begin
    step_o   = depth_i[5:3];
    raw      = SW'(width_i) * SW'(step_o);
    raw_up   = raw + SW'(PB - 1);
    stride_o = {raw_up[SW-1:LB], {LB{1'b0}}};
    fmt_o    = depth_i[5:4];
  end

  always_comb begin
    AST_STRIDE_PAD: assert (stride_o >= raw && (stride_o - raw) < SW'(PB)); // R1
  end
endmodule

// File: rtl/fbsag_win_check.sv
module fbsag_win_check #(
  parameter int unsigned DIM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIM_W-1:0] pos_x_i,
  input  logic [DIM_W-1:0] pos_y_i,
  input  logic [DIM_W-1:0] dst_w_i,
  input  logic [DIM_W-1:0] dst_h_i,
  input  logic [DIM_W-1:0] src_w_i,
  input  logic [DIM_W-1:0] src_h_i,
  input  logic [DIM_W-1:0] disp_w_i,
  input  logic [DIM_W-1:0] disp_h_i,
  output logic             err_o
);
  logic             neg;
  logic             over;
  logic             scale;
  logic [DIM_W:0]   right_edge;
  logic [DIM_W:0]   bottom_edge;

  always_comb begin
    neg         = pos_x_i[DIM_W-1] | pos_y_i[DIM_W-1];
    right_edge  = {1'b0, pos_x_i} + {1'b0, dst_w_i};
    bottom_edge = {1'b0, pos_y_i} + {1'b0, dst_h_i};
    over        = (right_edge > {1'b0, disp_w_i}) | (bottom_edge > {1'b0, disp_h_i});
    scale       = (src_w_i != dst_w_i) | (src_h_i != dst_h_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= neg | over | scale;
  end

  AST_NEG_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_x_i[DIM_W-1] || pos_y_i[DIM_W-1]) |=> err_o); // R8
  AST_NO_SCALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_w_i != dst_w_i) |=> err_o); // R10
endmodule

// File: rtl/fbsag_addr_ctr.sv
module fbsag_addr_ctr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SW     = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              line_end_i,
  input  logic              pix_vld_i,
  input  logic              block_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SW-1:0]     stride_i,
  input  logic [2:0]        step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              vld_o
);
  logic [ADDR_W-1:0] line_q;
  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] next_line;
  logic              pix_go;

  assign next_line = line_q + ADDR_W'(stride_i);
  assign pix_go    = pix_vld_i & ~frame_start_i & ~line_end_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      cur_q  <= '0;
      addr_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (frame_start_i) begin
        line_q <= base_i;
        cur_q  <= base_i;
      end else if (line_end_i) begin
        line_q <= next_line;
        cur_q  <= next_line;
      end else if (pix_vld_i) begin
        cur_q  <= cur_q + ADDR_W'(step_i);
        addr_o <= cur_q;
        vld_o  <= ~block_i;
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_start_i && !line_end_i && !pix_vld_i) |=> $stable(cur_q)); // R7
  AST_PIX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_go |=> (cur_q == $past(cur_q) + ADDR_W'($past(step_i)))); // R5
  AST_LINE_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_end_i && !frame_start_i) |=> (cur_q == $past(line_q) + ADDR_W'($past(stride_i)))); // R6
  AST_FRAME_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (line_q == $past(base_i))); // R4
  AST_SILENT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_i |=> !vld_o); // R11
endmodule

// File: rtl/fb_scan_addr_gen.sv
module fb_scan_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DIM_W  = 16,
  localparam int unsigned SW    = DIM_W + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic              frame_start_i,
  input  logic              line_end_i,
  input  logic              pix_vld_i,
  input  logic [DIM_W-1:0]  disp_w_i,
  input  logic [DIM_W-1:0]  disp_h_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_vld_o,
  output logic [1:0]        fmt_code_o,
  output logic [SW-1:0]     line_pitch_o,
  output logic [SW-1:0]     fetch_len_o,
  output logic              win_err_o,
  output logic [DIM_W-1:0]  ctr_right_o,
  output logic [DIM_W-1:0]  ctr_bottom_o
);
  import fbsag_pkg::*;

  logic [ADDR_W-1:0] base_pend_q;
  logic [DIM_W-1:0]  width_q;
  logic [5:0]        depth_q;
  logic [DIM_W-1:0]  pos_x_q, pos_y_q, dst_w_q, dst_h_q, src_w_q, src_h_q;
  logic [SW-1:0]     stride;
  logic [2:0]        step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_pend_q <= '0;
      width_q     <= '0;
      depth_q     <= DEPTH_RST;
      pos_x_q     <= '0;
      pos_y_q     <= '0;
      dst_w_q     <= '0;
      dst_h_q     <= '0;
      src_w_q     <= '0;
      src_h_q     <= '0;
    end else if (cfg_we_i) begin
      case (cfg_reg_e'(cfg_addr_i))
        REG_BASE:  base_pend_q <= cfg_wdata_i;
        REG_WIDTH: width_q     <= cfg_wdata_i[DIM_W-1:0];
        REG_DEPTH: depth_q     <= cfg_wdata_i[5:0];
        REG_POS:   {pos_y_q, pos_x_q} <= cfg_wdata_i[2*DIM_W-1:0];
        REG_DST:   {dst_h_q, dst_w_q} <= cfg_wdata_i[2*DIM_W-1:0];
        REG_SRC:   {src_h_q, src_w_q} <= cfg_wdata_i[2*DIM_W-1:0];
        default: ;
      endcase
    end
  end

  fbsag_stride #(.DIM_W(DIM_W), .SW(SW)) u_stride (
    .width_i  (width_q),
    .depth_i  (depth_q),
    .stride_o (stride),
    .fmt_o    (fmt_code_o),
    .step_o   (step)
  );

  fbsag_win_check #(.DIM_W(DIM_W)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pos_x_i  (pos_x_q),
    .pos_y_i  (pos_y_q),
    .dst_w_i  (dst_w_q),
    .dst_h_i  (dst_h_q),
    .src_w_i  (src_w_q),
    .src_h_i  (src_h_q),
    .disp_w_i (disp_w_i),
    .disp_h_i (disp_h_i),
    .err_o    (win_err_o)
  );

  fbsag_addr_ctr #(.ADDR_W(ADDR_W), .SW(SW)) u_ctr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .line_end_i    (line_end_i),
    .pix_vld_i     (pix_vld_i),
    .block_i       (win_err_o),
    .base_i        (base_pend_q),
    .stride_i      (stride),
    .step_i        (step),
    .addr_o        (rd_addr_o),
    .vld_o         (rd_vld_o)
  );

  // both pitch fields carry the same padded value
  assign line_pitch_o = stride;
  assign fetch_len_o  = stride;
  assign ctr_right_o  = disp_w_i - DIM_W'(1);
  assign ctr_bottom_o = disp_h_i - DIM_W'(1);

  AST_PITCH_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_pitch_o == fetch_len_o); // R2
endmodule

// File: tb/fb_scan_addr_gen_bench.sv
module fb_scan_addr_gen_bench;
  localparam int ADDR_W = 32;
  localparam int DIM_W  = 16;
  localparam int SW     = DIM_W + 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_addr = '0;
  logic [ADDR_W-1:0] cfg_wdata = '0;
  logic              frame_start = 1'b0, line_end = 1'b0, pix_vld = 1'b0;
  logic [DIM_W-1:0]  disp_w = 16'd64, disp_h = 16'd48;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_vld, win_err;
  logic [1:0]        fmt_code;
  logic [SW-1:0]     line_pitch, fetch_len;
  logic [DIM_W-1:0]  ctr_right, ctr_bottom;

  fb_scan_addr_gen #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_fb_scan_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .frame_start_i(frame_start), .line_end_i(line_end),
    .pix_vld_i(pix_vld), .disp_w_i(disp_w), .disp_h_i(disp_h),
    .rd_addr_o(rd_addr), .rd_vld_o(rd_vld), .fmt_code_o(fmt_code),
    .line_pitch_o(line_pitch), .fetch_len_o(fetch_len), .win_err_o(win_err),
    .ctr_right_o(ctr_right), .ctr_bottom_o(ctr_bottom)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int exp_q[$];
  int tag_q[$];

  // reference model state
  int m_width = 0, m_depth = 32, m_base_pend = 0, m_line = 0, m_cur = 0;
  bit m_block = 1'b0;
  int cur_tag = 5;

  function automatic int m_step();  return m_depth / 8; endfunction
  function automatic int m_pitch(); return ((m_width * m_step() + 15) / 16) * 16; endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected addresses as the design issues them
  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected address", int'(rd_addr), -1);
      end else begin
        int e, t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (int'(rd_addr) != e) begin
          n_bad++;
          $display("FAIL R%0d address actual=%0h expected=%0h", t, rd_addr, e);
        end
      end
    end
  end

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      3'd0: m_base_pend = int'(d);
      3'd1: m_width = int'(d[15:0]);
      3'd2: m_depth = int'(d[5:0]);
      default: ;
    endcase
  endtask

  task automatic do_frame();
    @(negedge clk); frame_start = 1'b1;
    m_line = m_base_pend; m_cur = m_base_pend;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic do_line_end();
    @(negedge clk); line_end = 1'b1;
    m_line = m_line + m_pitch(); m_cur = m_line;
    @(negedge clk); line_end = 1'b0;
  endtask

  task automatic do_pixels(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pix_vld = 1'b1;
      if (!m_block) begin exp_q.push_back(m_cur); tag_q.push_back(cur_tag); end
      m_cur = m_cur + m_step();
    end
    @(negedge clk); pix_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_pitch(input string req);
    check(int'(line_pitch) == m_pitch(), req, int'(line_pitch), m_pitch());
    check(int'(fetch_len) == m_pitch(), "R2 fetch_len", int'(fetch_len), m_pitch());
    check(int'(fmt_code) == m_depth / 16, "R3 fmt_code", int'(fmt_code), m_depth / 16);
  endtask

  task automatic check_err(input bit exp, input string req);
    idle(1);
    check(win_err == exp, req, int'(win_err), int'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R13 reset state
    check(rd_vld == 1'b0, "R13 rd_vld", int'(rd_vld), 0);
    check(win_err == 1'b0, "R13 win_err", int'(win_err), 0);
    check(fmt_code == 2'd2, "R13 fmt_code", int'(fmt_code), 2);
    check(line_pitch == '0, "R13 pitch", int'(line_pitch), 0);
    // R12 corners
    check(ctr_right == 16'd63, "R12 right", int'(ctr_right), 63);
    check(ctr_bottom == 16'd47, "R12 bottom", int'(ctr_bottom), 47);

    // R1 R3 pitch and format across depths
    cfg_write(3'd1, 32'd10); cfg_write(3'd2, 32'd16); check_pitch("R1 pitch 10x16");
    cfg_write(3'd2, 32'd24); check_pitch("R1 pitch 10x24");
    cfg_write(3'd2, 32'd32); check_pitch("R1 pitch 10x32");
    cfg_write(3'd1, 32'd5);  cfg_write(3'd2, 32'd8); check_pitch("R1 pitch 5x8");
    cfg_write(3'd1, 32'd8);  cfg_write(3'd2, 32'd32); check_pitch("R1 pitch exact 8x32");
    check(int'(line_pitch) == 32, "R1 exact multiple", int'(line_pitch), 32);

    // legal window 8x4 at origin
    cfg_write(3'd3, 32'h0000_0000);
    cfg_write(3'd4, 32'h0004_0008);
    cfg_write(3'd5, 32'h0004_0008);
    cfg_write(3'd0, 32'h0000_1000);
    check_err(1'b0, "R9 legal window");

    // R5 R6 R7 frame scan with a blanking gap mid-line
    do_frame();
    cur_tag = 5; do_pixels(5);
    idle(4);
    cur_tag = 7; do_pixels(3);
    cur_tag = 6; do_line_end(); do_pixels(8);
    // R4 base written mid-frame must not disturb this frame
    cfg_write(3'd0, 32'h0000_8000);
    cur_tag = 4; do_line_end(); do_pixels(8);
    do_frame(); do_pixels(4);

    // R5 16-bit depth: step 2, pitch 16
    cfg_write(3'd2, 32'd16);
    check_pitch("R1 pitch 8x16");
    cur_tag = 5; do_frame(); do_pixels(6);
    cur_tag = 6; do_line_end(); do_pixels(3);
    idle(2);

    // R8 negative x
    cfg_write(3'd3, 32'h0000_FFFF);
    check_err(1'b1, "R8 negative x");
    m_block = 1'b1; cur_tag = 11; do_pixels(4);
    idle(2);
    check(exp_q.size() == 0, "R11 no addresses while error", exp_q.size(), 0);
    cfg_write(3'd3, 32'hFFFF_0000);
    check_err(1'b1, "R8 negative y");
    // R9 exact right edge fit, then one past
    cfg_write(3'd3, 32'h0000_0038);
    check_err(1'b0, "R9 exact fit x=56 w=8");
    m_block = 1'b0;
    cfg_write(3'd3, 32'h0000_0039);
    check_err(1'b1, "R9 overflow x=57 w=8");
    cfg_write(3'd3, 32'h002D_0000);
    check_err(1'b1, "R9 overflow y=45 h=4");
    cfg_write(3'd3, 32'h002C_0000);
    check_err(1'b0, "R9 exact fit y=44 h=4");
    // R10 source/destination mismatch
    cfg_write(3'd5, 32'h0004_0009);
    check_err(1'b1, "R10 width mismatch");
    cfg_write(3'd5, 32'h0005_0008);
    check_err(1'b1, "R10 height mismatch");
    cfg_write(3'd5, 32'h0004_0008);
    check_err(1'b0, "R10 sizes match");
    // scan resumes after error clears
    cur_tag = 11; do_frame(); do_pixels(3);

    // R12 with other display size
    disp_w = 16'd1920; disp_h = 16'd1080;
    idle(1);
    check(ctr_right == 16'd1919, "R12 right 1920", int'(ctr_right), 1919);
    check(ctr_bottom == 16'd1079, "R12 bottom 1080", int'(ctr_bottom), 1079);

    idle(4);
    check(exp_q.size() == 0, "R5 all expected addresses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule